// File: doc/BRIEF.md
# Instruction Cache Maintenance and Fill Engine

This block owns a small direct-mapped instruction cache (valid bit, tag, four 64-bit doublewords and one parity bit per doubleword in every set) and executes maintenance commands on it. A command is a 3-bit operation code plus an address. Software uses it to invalidate a set by index or on a tag match, to move a set's tag between the cache and a pair of tag registers, to pull a whole block in from memory, or to push a matching block back out. During a fill each doubleword gets an even parity bit. When the check-enable input is high, the parity of the doubleword named by the command address is taken from the ECC register instead of being computed.

The address splits into byte offset [2:0], doubleword select [4:3], set index [7:5] and tag [39:8] (32 bits). The tag-register image is 32 bits wide: bits [31:8] hold tag[23:0], bits [7:1] are zero, and bit 0 is the valid flag. The high register's low 8 bits carry tag[31:24]. The ECC image has one bit per doubleword, with bit i belonging to doubleword i.

Memory traffic uses two valid/ready channels. On the request channel the engine raises `mem_req_valid`, and the transfer happens on the first clock edge where `mem_req_ready` is also high. Until that edge, address, write flag and write data stay frozen. Reads wait on the response channel: `mem_rsp_ready` is high only while a read is outstanding, and the data is taken on the edge where both `mem_rsp_valid` and `mem_rsp_ready` are high. Only one read is outstanding at a time. Writes expect no response. The command port and the register ports are plain signals.

Top module: `icm_engine`

## Requirements
- R1: A command is accepted on a clock edge where `cmd_start` is high and `busy` is low. `busy` is high from the next cycle until completion. `done` is high for exactly one cycle with `busy` low. Codes 0, 1, 2, 3, 4 and 7 raise `done` two cycles after acceptance.
- R2: Code 0 clears the valid flag of the set at address [7:5] whatever the tag. The tag is kept, and a later hit write-back to that set issues no memory traffic.
- R3: Code 1 presents `ld_tag_o` = {tag[23:0], 7'b0, valid} and `ld_ecc_o` = the set's four parity bits, and pulses `ld_we_o`. Parity values are reported as stored, including wrong ones.
- R4: Code 2 sets the set's tag to {tag_hi_i[7:0], tag_lo_i[31:8]} and its valid flag to tag_lo_i[0]. Data and parity are untouched.
- R5: Code 4 clears the valid flag only when the set is valid and its tag equals address [39:8]. Otherwise nothing changes.
- R6: Code 5 issues four read requests to the block base + 8·i for i = 0, 1, 2, 3 in that order, with one outstanding, and stores each response in doubleword i.
- R7: A filled doubleword gets the XOR of its 64 bits as its parity. If `ce_i` is high, doubleword address[4:3] instead gets `ecc_i[address[4:3]]`.
- R8: During a fill the set reads invalid. After the fourth response it holds tag address[39:8] and is valid.
- R9: Code 6 on a hit writes all four doublewords to block base + 8·i in ascending order, with no dirty condition. On a miss it issues no requests.
- R10: Codes 3 and 7 cause no memory traffic and change no set state.
- R11: A request held without ready keeps address, write flag and data stable. No request is raised while a read response is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; all sets become invalid |
| cmd_start | input | 1 | Command strobe |
| cmd_code | input | 3 | Operation code |
| cmd_addr | input | 40 | Command address |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| ce_i | input | 1 | Use register parity for the addressed doubleword during a fill |
| tag_lo_i | input | 32 | Low tag register image for tag stores |
| tag_hi_i | input | 8 | High tag bits for tag stores |
| ecc_i | input | 4 | ECC register image for parity override |
| ld_we_o | output | 1 | Pulse: load tag/ECC registers from ld_tag_o/ld_ecc_o |
| ld_tag_o | output | 32 | Tag image read from a set |
| ld_ecc_o | output | 4 | Parity bits read from a set |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request ready |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | 40 | Doubleword address of the request |
| mem_req_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_ready | output | 1 | Engine accepts a read response |
| mem_rsp_data | input | 64 | Read response data |

## Verification
The hardest situation to reach from the ports is a parity override on one chosen doubleword while the other three keep computed parity. The only way to see stored parity is a later tag load. The bench fills every set with the check-enable input set or clear and the selected doubleword rotating through all four positions. It uses data whose parity differs between doublewords and an ECC image whose bits disagree with the computed ones, then reads the parity back. Odd sets run under request back-pressure and delayed responses, so each fill also covers stalled handshakes.

// File: rtl/icm_pkg.sv
package icm_pkg;
  typedef enum logic [2:0] {
    OP_IDX_INV = 3'd0,
    OP_LD_TAG  = 3'd1,
    OP_ST_TAG  = 3'd2,
    OP_RSV3    = 3'd3,
    OP_HIT_INV = 3'd4,
    OP_FILL    = 3'd5,
    OP_HIT_WB  = 3'd6,
    OP_RSV7    = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXEC,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ
  } st_e;
endpackage

// File: rtl/icm_parity.sv
module icm_parity #(
  parameter int DW_W = 64
) (
  input  logic [DW_W-1:0] data,
  input  logic            ovr_en,
  input  logic            ovr_bit,
  output logic            par
);
  localparam int NB = DW_W / 8;
  logic [NB-1:0] byte_x;

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_byte
      assign byte_x[g] = ^data[g*8 +: 8];
    end
  endgenerate

  assign par = ovr_en ? ovr_bit : ^byte_x;
endmodule

// File: rtl/icm_array.sv
module icm_array #(
  parameter int SETS  = 8,
  parameter int BEATS = 4,
  parameter int DW_W  = 64,
  parameter int TAG_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(SETS)-1:0]  idx,
  input  logic [$clog2(BEATS)-1:0] beat,
  input  logic                     inv_en,
  input  logic                     tag_en,
  input  logic [TAG_W-1:0]         tag_val,
  input  logic                     tag_valid,
  input  logic                     dw_en,
  input  logic [DW_W-1:0]          dw_data,
  input  logic                     dw_par,
  output logic                     rd_valid,
  output logic [TAG_W-1:0]         rd_tag,
  output logic [BEATS-1:0]         rd_par,
  output logic [DW_W-1:0]          rd_data
);
  logic [SETS-1:0]                        valid_q;
  logic [SETS-1:0][TAG_W-1:0]             tag_q;
  logic [SETS-1:0][BEATS-1:0]             par_q;
  logic [SETS-1:0][BEATS-1:0][DW_W-1:0]   data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      tag_q   <= '0;
      par_q   <= '0;
      data_q  <= '0;
    end else begin
      if (tag_en) begin
        tag_q[idx]   <= tag_val;
        valid_q[idx] <= tag_valid;
      end else if (inv_en) begin
        valid_q[idx] <= 1'b0;
      end
      if (dw_en) begin
        data_q[idx][beat] <= dw_data;
        par_q[idx][beat]  <= dw_par;
      end
    end
  end

  assign rd_valid = valid_q[idx];
  assign rd_tag   = tag_q[idx];
  assign rd_par   = par_q[idx];
  assign rd_data  = data_q[idx][beat];
endmodule

// File: rtl/icm_ctrl.sv
module icm_ctrl
  import icm_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int SETS   = 8,
  parameter int BEATS  = 4,
  parameter int DW_W   = 64,
  parameter int TREG_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_start,
  input  logic [2:0]               cmd_code,
  input  logic [ADDR_W-1:0]        cmd_addr,
  output logic                     busy,
  output logic                     done,
  input  logic                     ce_i,
  input  logic [TREG_W-1:0]        tag_lo_i,
  input  logic [ADDR_W-$clog2(SETS)-$clog2(BEATS)-$clog2(DW_W/8)-TREG_W+7:0] tag_hi_i,
  input  logic [BEATS-1:0]         ecc_i,
  output logic                     ld_we_o,
  output logic [TREG_W-1:0]        ld_tag_o,
  output logic [BEATS-1:0]         ld_ecc_o,
  output logic [$clog2(SETS)-1:0]  idx,
  output logic [$clog2(BEATS)-1:0] beat,
  output logic                     inv_en,
  output logic                     tag_en,
  output logic [ADDR_W-$clog2(SETS)-$clog2(BEATS)-$clog2(DW_W/8)-1:0] tag_val,
  output logic                     tag_valid,
  output logic                     dw_en,
  output logic [DW_W-1:0]          dw_data,
  output logic                     ovr_en,
  output logic                     ovr_bit,
  input  logic                     rd_valid,
  input  logic [ADDR_W-$clog2(SETS)-$clog2(BEATS)-$clog2(DW_W/8)-1:0] rd_tag,
  input  logic [BEATS-1:0]         rd_par,
  input  logic [DW_W-1:0]          rd_data,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic                     mem_req_we,
  output logic [ADDR_W-1:0]        mem_req_addr,
  output logic [DW_W-1:0]          mem_req_wdata,
  input  logic                     mem_rsp_valid,
  output logic                     mem_rsp_ready,
  input  logic [DW_W-1:0]          mem_rsp_data
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int BEAT_W = $clog2(BEATS);
  localparam int BYTE_W = $clog2(DW_W / 8);
  localparam int OFF_W  = BEAT_W + BYTE_W;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int TLO_W  = TREG_W - 8;
  localparam int THI_W  = TAG_W - TLO_W;
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  st_e               st_q;
  op_e               code_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BEAT_W-1:0] beat_q;
  logic              done_q;
  logic              ld_we_q;
  logic [TREG_W-1:0] ld_tag_q;
  logic [BEATS-1:0]  ld_ecc_q;

  logic [TAG_W-1:0]  req_tag;
  logic [BEAT_W-1:0] dw_sel;
  logic              hit;
  logic              last_beat;
  logic              is_exec;
  logic              unused_ok;

  assign req_tag   = addr_q[ADDR_W-1 -: TAG_W];
  assign dw_sel    = addr_q[BYTE_W +: BEAT_W];
  assign idx       = addr_q[OFF_W +: IDX_W];
  assign beat      = beat_q;
  assign hit       = rd_valid && (rd_tag == req_tag);
  assign last_beat = (beat_q == LAST);
  assign is_exec   = (st_q == ST_EXEC);
  assign unused_ok = ^{addr_q[BYTE_W-1:0], tag_lo_i[7:1]};

  // array controls
  assign inv_en    = is_exec && ((code_q == OP_IDX_INV) || (code_q == OP_FILL) ||
                                 ((code_q == OP_HIT_INV) && hit));
  assign tag_en    = (is_exec && (code_q == OP_ST_TAG)) ||
                     ((st_q == ST_RD_WAIT) && mem_rsp_valid && last_beat);
  assign tag_val   = is_exec ? {tag_hi_i[THI_W-1:0], tag_lo_i[TREG_W-1 -: TLO_W]} : req_tag;
  assign tag_valid = is_exec ? tag_lo_i[0] : 1'b1;
  assign dw_en     = (st_q == ST_RD_WAIT) && mem_rsp_valid;
  assign dw_data   = mem_rsp_data;
  assign ovr_en    = ce_i && (beat_q == dw_sel);
  assign ovr_bit   = ecc_i[beat_q];

  // memory channels
  assign mem_req_valid = (st_q == ST_RD_REQ) || (st_q == ST_WR_REQ);
  assign mem_req_we    = (st_q == ST_WR_REQ);
  assign mem_req_addr  = {addr_q[ADDR_W-1:OFF_W], beat_q, {BYTE_W{1'b0}}};
  assign mem_req_wdata = rd_data;
  assign mem_rsp_ready = (st_q == ST_RD_WAIT);

  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign ld_we_o  = ld_we_q;
  assign ld_tag_o = ld_tag_q;
  assign ld_ecc_o = ld_ecc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      code_q   <= OP_IDX_INV;
      addr_q   <= '0;
      beat_q   <= '0;
      done_q   <= 1'b0;
      ld_we_q  <= 1'b0;
      ld_tag_q <= '0;
      ld_ecc_q <= '0;
    end else begin
      done_q  <= 1'b0;
      ld_we_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (cmd_start) begin
            code_q <= op_e'(cmd_code);
            addr_q <= cmd_addr;
            beat_q <= '0;
            st_q   <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          case (code_q)
            OP_FILL: st_q <= ST_RD_REQ;
            OP_HIT_WB: begin
              if (hit) st_q <= ST_WR_REQ;
              else begin st_q <= ST_IDLE; done_q <= 1'b1; end
            end
            OP_LD_TAG: begin
              ld_tag_q <= {rd_tag[TLO_W-1:0], {(TREG_W-TLO_W-1){1'b0}}, rd_valid};
              ld_ecc_q <= rd_par;
              ld_we_q  <= 1'b1;
              st_q     <= ST_IDLE;
              done_q   <= 1'b1;
            end
            default: begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end
          endcase
        end
        ST_RD_REQ: if (mem_req_ready) st_q <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (mem_rsp_valid) begin
            if (last_beat) begin st_q <= ST_IDLE; done_q <= 1'b1; end
            else begin beat_q <= beat_q + 1'b1; st_q <= ST_RD_REQ; end
          end
        end
        ST_WR_REQ: begin
          if (mem_req_ready) begin
            if (last_beat) begin st_q <= ST_IDLE; done_q <= 1'b1; end
            else beat_q <= beat_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R1: completion pulse never overlaps busy; acceptance raises busy
  p_done_not_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_start) |=> busy);
  // R10: reserved codes finish at once and touch memory never
  p_rsv_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_exec && (code_q == OP_RSV3 || code_q == OP_RSV7)) |=> (done && !mem_req_valid));
  // R11: stalled request holds its payload
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));
  // R11: no request while waiting for read data
  p_rsp_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> !mem_req_valid);
endmodule

// File: rtl/icm_engine.sv
module icm_engine #(
  parameter int ADDR_W = 40,
  parameter int SETS   = 8,
  parameter int BEATS  = 4,
  parameter int DW_W   = 64,
  parameter int TREG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [2:0]        cmd_code,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              busy,
  output logic              done,
  input  logic              ce_i,
  input  logic [TREG_W-1:0] tag_lo_i,
  input  logic [ADDR_W-$clog2(SETS)-$clog2(BEATS)-$clog2(DW_W/8)-TREG_W+7:0] tag_hi_i,
  input  logic [BEATS-1:0]  ecc_i,
  output logic              ld_we_o,
  output logic [TREG_W-1:0] ld_tag_o,
  output logic [BEATS-1:0]  ld_ecc_o,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DW_W-1:0]   mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DW_W-1:0]   mem_rsp_data
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int BEAT_W = $clog2(BEATS);
  localparam int BYTE_W = $clog2(DW_W / 8);
  localparam int TAG_W  = ADDR_W - IDX_W - BEAT_W - BYTE_W;
  localparam int TLO_W  = TREG_W - 8;

  logic [IDX_W-1:0]  idx;
  logic [BEAT_W-1:0] beat;
  logic              inv_en, tag_en, tag_valid, dw_en, ovr_en, ovr_bit, dw_par;
  logic [TAG_W-1:0]  tag_val, rd_tag;
  logic [DW_W-1:0]   dw_data, rd_data;
  logic              rd_valid;
  logic [BEATS-1:0]  rd_par;

  icm_ctrl #(.ADDR_W(ADDR_W), .SETS(SETS), .BEATS(BEATS), .DW_W(DW_W), .TREG_W(TREG_W)) u_ctrl (
    .clk, .rst_n, .cmd_start, .cmd_code, .cmd_addr, .busy, .done,
    .ce_i, .tag_lo_i, .tag_hi_i, .ecc_i, .ld_we_o, .ld_tag_o, .ld_ecc_o,
    .idx, .beat, .inv_en, .tag_en, .tag_val, .tag_valid, .dw_en, .dw_data,
    .ovr_en, .ovr_bit, .rd_valid, .rd_tag, .rd_par, .rd_data,
    .mem_req_valid, .mem_req_ready, .mem_req_we, .mem_req_addr, .mem_req_wdata,
    .mem_rsp_valid, .mem_rsp_ready, .mem_rsp_data
  );

  icm_parity #(.DW_W(DW_W)) u_par (
    .data(dw_data), .ovr_en(ovr_en), .ovr_bit(ovr_bit), .par(dw_par)
  );

  icm_array #(.SETS(SETS), .BEATS(BEATS), .DW_W(DW_W), .TAG_W(TAG_W)) u_arr (
    .clk, .rst_n, .idx, .beat, .inv_en, .tag_en, .tag_val, .tag_valid,
    .dw_en, .dw_data, .dw_par, .rd_valid, .rd_tag, .rd_par, .rd_data
  );

  // R8: the set under fill reads invalid until the final beat lands
  p_fill_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_ready || (mem_req_valid && !mem_req_we)) |-> !rd_valid);
  // R2: index invalidate leaves the set invalid at completion
  p_idx_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_start && cmd_code == 3'd0) |=> ##1 (done && !rd_valid));
  // R4: tag store takes the register images sampled in the execute cycle
  p_store_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_start && cmd_code == 3'd2) |=> ##1
      (rd_valid == $past(tag_lo_i[0]) &&
       rd_tag == $past({tag_hi_i, tag_lo_i[TREG_W-1 -: TLO_W]})));
  // R9: write-back traffic only from a valid set
  p_wb_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> rd_valid);
endmodule

// File: tb/sim_icm_engine.sv
module sim_icm_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [2:0]  cmd_code = '0;
  logic [39:0] cmd_addr = '0;
  logic        busy, done;
  logic        ce_i = 1'b0;
  logic [31:0] tag_lo_i = '0;
  logic [7:0]  tag_hi_i = '0;
  logic [3:0]  ecc_i = '0;
  logic        ld_we_o;
  logic [31:0] ld_tag_o;
  logic [3:0]  ld_ecc_o;
  logic        mem_req_valid, mem_req_we, mem_rsp_ready;
  logic        mem_req_ready = 1'b0;
  logic [39:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  int checks = 0, errors = 0;
  int wd = 0, cyc = 0;
  bit bp = 0;
  bit rsp_pend = 0;
  int rsp_dly = 0;
  logic [39:0] rsp_addr;
  int rd_n = 0, wr_n = 0;
  logic [39:0] rd_log [0:127];
  logic [39:0] wr_log [0:127];
  logic [63:0] wd_log [0:127];

  always #2 clk = ~clk;

  icm_engine u0 (.*);

  function automatic logic [63:0] dat(input logic [39:0] a);
    return {a[31:0] ^ 32'h5A3C96E1, a[31:0] * 32'h9E3779B1};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: drives at negedge, logs transfers that commit at the next posedge
  always @(negedge clk) begin
    cyc++;
    if (rsp_pend) begin
      if (rsp_dly == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = dat(rsp_addr);
        if (mem_rsp_ready) rsp_pend = 0;
      end else begin
        rsp_dly--;
        mem_rsp_valid = 1'b0;
      end
    end else mem_rsp_valid = 1'b0;
    mem_req_ready = bp ? ((cyc % 3) == 0) : 1'b1;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        if (wr_n < 128) begin wr_log[wr_n] = mem_req_addr; wd_log[wr_n] = mem_req_wdata; end
        wr_n++;
      end else begin
        if (rd_n < 128) rd_log[rd_n] = mem_req_addr;
        rd_n++;
        rsp_pend = 1;
        rsp_addr = mem_req_addr;
        rsp_dly  = bp ? (cyc % 4) : 0;
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run(input logic [2:0] code, input logic [39:0] addr, output int lat);
    @(negedge clk);
    cmd_code = code; cmd_addr = addr; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    chk(busy === 1'b1, "R1", "busy after accept", 64'(busy), 64'd1);
    lat = 1;
    while (done !== 1'b1 && lat < 400) begin @(negedge clk); lat++; end
    if (lat >= 400) chk(1'b0, "R1", "command timeout", 64'(lat), 64'd0);
    else chk(busy === 1'b0, "R1", "busy low with done", 64'(busy), 64'd0);
  endtask

  task automatic ldtag(output logic [31:0] t, output logic [3:0] e);
    int lat;
    run(3'd1, cmd_addr, lat);
    chk(ld_we_o === 1'b1, "R3", "load strobe", 64'(ld_we_o), 64'd1);
    chk(lat == 2, "R1", "load tag latency", 64'(lat), 64'd2);
    t = ld_tag_o; e = ld_ecc_o;
  endtask

  initial begin
    int lat, r0, w0;
    logic [31:0] t;
    logic [3:0] e, exp_e;
    logic [31:0] ta, tb, tc;
    logic [39:0] la, lb;
    logic [1:0] dsel;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1", "reset idle", {busy, done}, 64'd0);
    chk(mem_req_valid === 1'b0, "R11", "reset no request", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 0; s < 8; s++) begin
      ta = 32'hC0DE0000 + s * 17;
      tb = 32'h3B000000 + s * 257;
      tc = 32'h00770000 + s;
      la = {ta, 3'(s), 5'b0};
      lb = {tb, 3'(s), 5'b0};
      dsel = 2'(s);
      bp = s[0];
      ce_i = (s >= 4);
      ecc_i = 4'b0101 ^ 4'(s);

      // fill
      r0 = rd_n; w0 = wr_n;
      run(3'd5, la + 40'(dsel) * 8 + 40'd3, lat);
      chk(rd_n - r0 == 4, "R11", "fill read count", 64'(rd_n - r0), 64'd4);
      chk(wr_n == w0, "R6", "fill writes", 64'(wr_n - w0), 64'd0);
      for (int i = 0; i < 4; i++)
        chk(rd_log[r0 + i] == la + 40'(i * 8), "R6", "fill read address", rd_log[r0 + i], la + 40'(i * 8));
      ce_i = 1'b0;
      ecc_i = 4'b0000;
      ldtag(t, e);
      chk(t == {ta[23:0], 7'b0, 1'b1}, "R8", "tag after fill", t, {ta[23:0], 7'b0, 1'b1});
      for (int i = 0; i < 4; i++)
        exp_e[i] = ((s >= 4) && i == int'(dsel)) ? (4'b0101 ^ 4'(s)) >> i : ^dat(la + 40'(i * 8));
      chk(e == exp_e, "R7", "fill parity", e, exp_e);

      // hit write-back and miss write-back
      w0 = wr_n; r0 = rd_n;
      run(3'd6, la + 40'd16, lat);
      chk(wr_n - w0 == 4 && rd_n == r0, "R9", "hit wb count", 64'(wr_n - w0), 64'd4);
      for (int i = 0; i < 4; i++) begin
        chk(wr_log[w0 + i] == la + 40'(i * 8), "R9", "wb address", wr_log[w0 + i], la + 40'(i * 8));
        chk(wd_log[w0 + i] == dat(la + 40'(i * 8)), "R9", "wb data", wd_log[w0 + i], dat(la + 40'(i * 8)));
      end
      w0 = wr_n;
      run(3'd6, lb, lat);
      chk(wr_n == w0 && lat == 2, "R9", "miss wb silent", 64'(wr_n - w0), 64'd0);

      // hit invalidate: miss then hit
      run(3'd4, lb, lat);
      chk(lat == 2, "R1", "hit inv latency", 64'(lat), 64'd2);
      ldtag(t, e);
      chk(t[0] == 1'b1, "R5", "miss keeps valid", 64'(t[0]), 64'd1);
      run(3'd4, la + 40'd8, lat);
      ldtag(t, e);
      chk(t == {ta[23:0], 7'b0, 1'b0}, "R5", "hit clears valid", t, {ta[23:0], 7'b0, 1'b0});

      // tag store, then write-back under the new tag
      tag_lo_i = {tb[23:0], 7'h55, 1'b1};
      tag_hi_i = tb[31:24];
      run(3'd2, la, lat);
      chk(lat == 2, "R1", "store tag latency", 64'(lat), 64'd2);
      tag_lo_i = '0; tag_hi_i = '0;
      ldtag(t, e);
      chk(t == {tb[23:0], 7'b0, 1'b1}, "R4", "stored tag", t, {tb[23:0], 7'b0, 1'b1});
      chk(e == exp_e, "R4", "parity kept", e, exp_e);
      w0 = wr_n;
      run(3'd6, lb, lat);
      chk(wr_n - w0 == 4, "R4", "wb after store count", 64'(wr_n - w0), 64'd4);
      for (int i = 0; i < 4; i++) begin
        chk(wr_log[w0 + i] == lb + 40'(i * 8), "R9", "wb new address", wr_log[w0 + i], lb + 40'(i * 8));
        chk(wd_log[w0 + i] == dat(la + 40'(i * 8)), "R4", "data kept", wd_log[w0 + i], dat(la + 40'(i * 8)));
      end

      // reserved codes
      r0 = rd_n; w0 = wr_n;
      run(3'd3, lb, lat);
      chk(lat == 2, "R10", "code 3 latency", 64'(lat), 64'd2);
      run(3'd7, {tc, 3'(s), 5'b0}, lat);
      chk(lat == 2, "R10", "code 7 latency", 64'(lat), 64'd2);
      chk(rd_n == r0 && wr_n == w0, "R10", "reserved no traffic", 64'(rd_n - r0 + wr_n - w0), 64'd0);
      ldtag(t, e);
      chk(t == {tb[23:0], 7'b0, 1'b1} && e == exp_e, "R10", "reserved no change", t, {tb[23:0], 7'b0, 1'b1});

      // index invalidate with an unrelated tag
      run(3'd0, {tc, 3'(s), 5'b0}, lat);
      chk(lat == 2, "R1", "index inv latency", 64'(lat), 64'd2);
      ldtag(t, e);
      chk(t == {tb[23:0], 7'b0, 1'b0}, "R2", "index inv clears valid", t, {tb[23:0], 7'b0, 1'b0});
      w0 = wr_n;
      run(3'd6, lb, lat);
      chk(wr_n == w0, "R2", "invalid set no wb", 64'(wr_n - w0), 64'd0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule